// File: doc/BRIEF.md
# Station Address Hash Filter

This block turns a 48-bit destination address into the 6-bit hash index used for individual-address filtering. It then looks that index up in a 64-entry bit table held as two 32-bit halves. The address arrives one byte per cycle on a valid-qualified byte input. The block runs a reflected CRC-32 over the six bytes, folding the eight bits of each byte in one cycle. The top six bits of the final CRC pick one bit of the table, and that bit is the hash hit.

A simple write port loads the two table halves. A second write port loads a programmed station address. The block compares this station address with the incoming one and reports an exact hit beside the hash hit. Both results and the index are registered. They are announced by a one-cycle result strobe and hold their values until the next address completes.

Top module: `hash_filter_top`

## Requirements
- R1: After synchronous reset, `res_valid`, `busy`, `hash_index`, `hash_hit` and `exact_hit` are all 0, and both table halves and the station address are zero.
- R2: The CRC starts from all ones. Bytes are consumed in arrival order (byte 0 first), each byte least significant bit first. On every bit the register shifts right by one and is XORed with 0xEDB88320 when the input bit differs from the register's bit 0. `hash_index` equals bits 31..26 of the final CRC.
- R3: An index of 32 or more makes `hash_hit` equal to bit (index−32) of the upper table half. A smaller index makes it equal to bit (index) of the lower half.
- R4: `res_valid` is high for exactly one cycle: the cycle after the sixth byte is accepted. `hash_index`, `hash_hit` and `exact_hit` change only together with that strobe and hold their values otherwise.
- R5: `busy` is high from the cycle after a first byte is accepted through the `res_valid` cycle. A byte offered during the `res_valid` cycle is ignored and does not start a new address.
- R6: Cycles with `in_valid` low between bytes of one address stall the computation without altering it.
- R7: `tbl_sel`=0 writes the lower table half and `tbl_sel`=1 writes the upper half. A write on the same edge as the sixth byte takes effect only after that address's lookup.
- R8: Station word 0 (`sta_sel`=0) holds bytes 0..3, with byte 0 in bits 31..24. Word 1 (`sta_sel`=1) holds byte 4 in bits 31..24 and byte 5 in bits 23..16, and its bits 15..0 are ignored. `exact_hit` is 1 when all six bytes match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address byte is present |
| in_byte | input | 8 | Address byte, byte 0 first |
| tbl_we | input | 1 | Table half write strobe |
| tbl_sel | input | 1 | 0 lower half, 1 upper half |
| tbl_wdata | input | 32 | Table half write data |
| sta_we | input | 1 | Station address write strobe |
| sta_sel | input | 1 | Station word select |
| sta_wdata | input | 32 | Station word write data |
| busy | output | 1 | Address in progress or result cycle; first byte not taken |
| res_valid | output | 1 | One-cycle result strobe |
| hash_index | output | 6 | Computed hash index |
| hash_hit | output | 1 | Selected table bit |
| exact_hit | output | 1 | Address equals station address |

## Verification
The assertions check the strobe timing on every cycle. They confirm that a sixth byte is followed by a single-cycle `res_valid`, that `busy` covers that cycle, and that the CRC sits at its preset whenever the block is idle. They also confirm that results hold between strobes and that table writes land in the selected half only. The bench scenarios are the only check on the numerical hash value and the table bit it selects. They also show that a byte offered in the result cycle is dropped, that stalls between bytes leave the result unchanged, and how a table write on the sixth byte's edge interacts with the lookup.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int          CRC_W      = 32;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DONE    = 2'd2
  } hf_state_e;
endpackage

// File: rtl/hf_crc_byte.sv
module hf_crc_byte #(
  parameter int          CRC_W  = 32,
  parameter int          BYTE_W = 8,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_out
);
  // One reflected CRC step per input bit, least significant bit first.
  logic [CRC_W-1:0] chain [0:BYTE_W];

  assign chain[0] = crc_in;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    assign chain[g+1] = (chain[g] >> 1) ^
                        ((chain[g][0] ^ din[g]) ? POLY[CRC_W-1:0] : '0);
  end

  assign crc_out = chain[BYTE_W];
endmodule

// File: rtl/hf_table.sv
module hf_table #(
  parameter int IDX_W = 6,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_out
);
  logic [REG_W-1:0] lo_q;
  logic [REG_W-1:0] hi_q;
  logic [IDX_W-2:0] pos;

  assign pos = idx[IDX_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (we) begin
      if (sel) hi_q <= wdata;
      else     lo_q <= wdata;
    end
  end

  // Top index bit picks the half; remaining bits pick the position.
  assign bit_out = idx[IDX_W-1] ? hi_q[pos] : lo_q[pos];

  a_r7_lo_write: assert property (@(posedge clk) disable iff (rst)
    (we && !sel) |=> (lo_q == $past(wdata)));
  a_r7_hi_untouched: assert property (@(posedge clk) disable iff (rst)
    !(we && sel) |=> $stable(hi_q));
  a_r7_lo_untouched: assert property (@(posedge clk) disable iff (rst)
    !(we && !sel) |=> $stable(lo_q));
endmodule

// File: rtl/hf_station.sv
module hf_station #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 6,
  parameter int REG_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic                      sel,
  input  logic [REG_W-1:0]          wdata,
  input  logic [N_BYTES*BYTE_W-1:0] addr,
  output logic                      equal
);
  localparam int ADDR_W = N_BYTES * BYTE_W;
  localparam int TAIL_W = ADDR_W - REG_W;

  logic [REG_W-1:0]  head_q;
  logic [TAIL_W-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (we) begin
      if (sel) tail_q <= wdata[REG_W-1 -: TAIL_W];
      else     head_q <= wdata;
    end
  end

  assign equal = (addr == {head_q, tail_q});

  a_r8_tail_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && sel) |=> $stable(tail_q));
endmodule

// File: rtl/hash_filter_top.sv
module hash_filter_top #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 6,
  parameter int IDX_W   = 6,
  parameter int REG_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              tbl_we,
  input  logic              tbl_sel,
  input  logic [REG_W-1:0]  tbl_wdata,
  input  logic              sta_we,
  input  logic              sta_sel,
  input  logic [REG_W-1:0]  sta_wdata,
  output logic              busy,
  output logic              res_valid,
  output logic [IDX_W-1:0]  hash_index,
  output logic              hash_hit,
  output logic              exact_hit
);
  import hf_pkg::*;

  localparam int ADDR_W = N_BYTES * BYTE_W;
  localparam int CNT_W  = $clog2(N_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_BYTES - 1);

  hf_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nx;
  logic [IDX_W-1:0]  idx_nx;
  logic              take;
  logic              last;
  logic              tbl_bit;
  logic              sta_eq;

  assign take    = in_valid && (state_q != ST_DONE);
  assign last    = take && (cnt_q == LAST_CNT);
  assign addr_nx = {addr_q[ADDR_W-BYTE_W-1:0], in_byte};
  assign idx_nx  = crc_nx[CRC_W-1 -: IDX_W];

  hf_crc_byte #(
    .CRC_W (CRC_W),
    .BYTE_W(BYTE_W),
    .POLY  (CRC_POLY)
  ) u_crc (
    .crc_in (crc_q),
    .din    (in_byte),
    .crc_out(crc_nx)
  );

  hf_table #(
    .IDX_W(IDX_W),
    .REG_W(REG_W)
  ) u_table (
    .clk    (clk),
    .rst    (rst),
    .we     (tbl_we),
    .sel    (tbl_sel),
    .wdata  (tbl_wdata),
    .idx    (idx_nx),
    .bit_out(tbl_bit)
  );

  hf_station #(
    .BYTE_W (BYTE_W),
    .N_BYTES(N_BYTES),
    .REG_W  (REG_W)
  ) u_station (
    .clk  (clk),
    .rst  (rst),
    .we   (sta_we),
    .sel  (sta_sel),
    .wdata(sta_wdata),
    .addr (addr_nx),
    .equal(sta_eq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      crc_q      <= CRC_PRESET[CRC_W-1:0];
      addr_q     <= '0;
      res_valid  <= 1'b0;
      hash_index <= '0;
      hash_hit   <= 1'b0;
      exact_hit  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state_q)
        ST_DONE: state_q <= ST_IDLE;
        default: begin
          if (last) begin
            state_q    <= ST_DONE;
            cnt_q      <= '0;
            crc_q      <= CRC_PRESET[CRC_W-1:0];
            addr_q     <= '0;
            res_valid  <= 1'b1;
            hash_index <= idx_nx;
            hash_hit   <= tbl_bit;
            exact_hit  <= sta_eq;
          end else if (take) begin
            state_q <= ST_COLLECT;
            cnt_q   <= cnt_q + 1'b1;
            crc_q   <= crc_nx;
            addr_q  <= addr_nx;
          end
        end
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  a_r4_after_sixth: assert property (@(posedge clk) disable iff (rst)
    last |=> res_valid);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(hash_index) && $stable(hash_hit) && $stable(exact_hit)));
  a_r5_busy_on_result: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy);
  a_r5_drop_in_result: assert property (@(posedge clk) disable iff (rst)
    (res_valid && in_valid) |=> !busy);
  a_r2_idle_preset: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (crc_q == CRC_PRESET[CRC_W-1:0]));
endmodule

// File: tb/tb_hash_filter_top.sv
module tb_hash_filter_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        tbl_we = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [31:0] tbl_wdata = '0;
  logic        sta_we = 1'b0;
  logic        sta_sel = 1'b0;
  logic [31:0] sta_wdata = '0;
  logic        busy, res_valid, hash_hit, exact_hit;
  logic [5:0]  hash_index;

  int checks = 0;
  int errors = 0;
  string scen = "R1";

  always #2 clk = ~clk;

  hash_filter_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
    .sta_we(sta_we), .sta_sel(sta_sel), .sta_wdata(sta_wdata),
    .busy(busy), .res_valid(res_valid), .hash_index(hash_index),
    .hash_hit(hash_hit), .exact_hit(exact_hit)
  );

  // Behavioural reference model
  logic [7:0]  m_q[$];
  bit          m_done;
  logic [31:0] m_lo, m_hi, m_w0, m_w1;
  logic        e_mv, e_busy, e_hit, e_exact;
  logic [5:0]  e_idx;
  bit          started = 0;

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[i]) begin
      logic [7:0] v = b[i];
      for (int k = 0; k < 8; k++) begin
        if (v[0] != c[0]) c = (c >> 1) ^ 32'hEDB88320;
        else              c = c >> 1;
        v = v >> 1;
      end
    end
    return c;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_q.delete(); m_done = 0;
      m_lo = 0; m_hi = 0; m_w0 = 0; m_w1 = 0;
      e_mv = 0; e_busy = 0; e_hit = 0; e_exact = 0; e_idx = 0;
    end else begin
      e_mv = 0;
      if (m_done) m_done = 0;
      else if (in_valid) begin
        m_q.push_back(in_byte);
        if (m_q.size() == 6) begin
          int ix;
          ix = int'(ref_crc(m_q) >> 26);
          e_idx = 6'(ix);
          e_hit = (ix >= 32) ? m_hi[ix-32] : m_lo[ix];
          e_exact = (m_w0 == {m_q[0], m_q[1], m_q[2], m_q[3]}) &&
                    (m_w1[31:16] == {m_q[4], m_q[5]});
          e_mv = 1; m_done = 1;
          m_q.delete();
        end
      end
      e_busy = (m_q.size() != 0) || m_done;
      if (tbl_we) begin if (tbl_sel) m_hi = tbl_wdata; else m_lo = tbl_wdata; end
      if (sta_we) begin if (sta_sel) m_w1 = sta_wdata; else m_w0 = sta_wdata; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) actual %0h expected %0h at %0t", req, scen, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) if (started) begin
    chk("R5", 32'(busy), 32'(e_busy));
    chk("R4", 32'(res_valid), 32'(e_mv));
    chk("R2", 32'(hash_index), 32'(e_idx));
    chk("R3", 32'(hash_hit), 32'(e_hit));
    chk("R8", 32'(exact_hit), 32'(e_exact));
  end

  task automatic wr_tbl(input logic s, input logic [31:0] d);
    tbl_we = 1; tbl_sel = s; tbl_wdata = d; @(negedge clk); tbl_we = 0;
  endtask

  task automatic wr_sta(input logic s, input logic [31:0] d);
    sta_we = 1; sta_sel = s; sta_wdata = d; @(negedge clk); sta_we = 0;
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1; in_byte = a[47-8*i -: 8];
      @(negedge clk);
      in_valid = 0;
      if (i < 5) repeat (gap) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state seen at the ports
    chk("R1", {27'd0, busy, res_valid, hash_hit, exact_hit, 1'b0}, 32'd0);
    chk("R1", 32'(hash_index), 32'd0);
    scen = "R1";
    send(48'h001122334455, 0);

    scen = "R3";
    wr_tbl(0, 32'hFFFFFFFF);
    for (int i = 0; i < 8; i++) send({16'h0A00 + 16'(i), 32'(i * 77)}, 0);
    wr_tbl(0, 32'h0); wr_tbl(1, 32'hFFFFFFFF);
    for (int i = 0; i < 8; i++) send({16'h0B00 + 16'(i), 32'(i * 91)}, 0);
    send(48'hFFFFFFFFFFFF, 0);
    send(48'h000000000000, 0);

    scen = "R6";
    wr_tbl(0, 32'hA5A5_5A5A); wr_tbl(1, 32'h0F0F_3C3C);
    for (int i = 0; i < 6; i++) send({$urandom, $urandom} , i % 3);

    scen = "R8";
    wr_sta(0, 32'h02AB_CDEF); wr_sta(1, 32'h1234_BEEF);
    send(48'h02ABCDEF1234, 1);
    wr_sta(1, 32'h1234_0000);
    send(48'h02ABCDEF1234, 0);
    send(48'h02ABCDEF1235, 0);
    send(48'h03ABCDEF1234, 0);

    scen = "R5";
    for (int i = 0; i < 6; i++) begin
      in_valid = 1; in_byte = 8'(8'h30 + i); @(negedge clk);
    end
    in_byte = 8'hEE; @(negedge clk); // offered during result cycle
    in_valid = 0;
    repeat (2) @(negedge clk);
    send(48'h303132333435, 0);

    scen = "R7";
    wr_tbl(1, 32'h0); wr_tbl(0, 32'h0);
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_byte = 8'(8'h40 + i); @(negedge clk);
    end
    in_byte = 8'h45; tbl_we = 1; tbl_sel = 0; tbl_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    tbl_we = 0; tbl_sel = 1; tbl_wdata = 32'hFFFFFFFF; tbl_we = 1;
    in_valid = 0; @(negedge clk); tbl_we = 0;
    repeat (2) @(negedge clk);
    send(48'h404142434445, 0);

    scen = "R2";
    for (int i = 0; i < 40; i++) begin
      if (i % 10 == 0) begin wr_tbl(0, $urandom); wr_tbl(1, $urandom); end
      send({$urandom, $urandom}, i % 2);
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule